// File: doc/BRIEF.md
# I2C Master Byte Receiver Engine

This block is the data path of an I2C master while it is reading from a slave. A separate clock generator produces the SCL waveform. It hands this engine one strobe per data bit, taken at the rising SCL edge with SDA valid. It also gives one strobe at the end of the ninth, acknowledge, clock. The engine shifts the eight data bits in MSB first. During the acknowledge clock it requests that SDA be pulled low, or leaves SDA high as a NACK. When that clock ends it moves the byte into a holding register and raises the receive-full flag.

The engine is double-buffered. A byte can shift in while software still holds the previous one. If a byte completes while receive-full is still set, the engine enters the byte-transfer-finished (BTF) state. The new byte then waits in the shift register and SCL is held low. A read of the holding register in that state moves the waiting byte across and lets the bus run again. Software can still change the acknowledge decision for a byte up to the end of that byte's acknowledge clock, which lets it NACK the final byte. A position mode makes the acknowledge setting apply to the byte after the one currently shifting, which suits two-byte reads.

The controller has four states. IDLE: receive not enabled. SHIFT: counting data bits. ACK: the acknowledge clock is in progress. HOLD: BTF, with the bus frozen. The transitions are:
- IDLE→SHIFT when receive is enabled.
- SHIFT→IDLE when receive is disabled between bytes.
- SHIFT→ACK on the eighth bit strobe.
- ACK→SHIFT when the acknowledge clock ends and the holding register is free or being read.
- ACK→HOLD when the acknowledge clock ends and the holding register is still full.
- HOLD→SHIFT when the holding register is read.

Top module: `i2c_mrx_engine`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears receive-full, BTF, the stretch request, the SDA pull request and the bit count. After reset `rx_data` reads 0x00.
- R2: With `rx_en` high, each `bit_stb` shifts `sda_in` in MSB first. After eight strobes and one `ack_slot_stb`, the byte appears on `rx_data` and `rxne` is 1, both from the cycle after the `ack_slot_stb` edge.
- R3: With `pos_en` low, `sda_pull_low` is 1 during the acknowledge clock (after the eighth bit, up to `ack_slot_stb`) exactly when `ack_en` is 1. With `ack_en` 0 the line is left released (NACK).
- R4: With `pos_en` low, a change to `ack_en` made during the acknowledge clock, before `ack_slot_stb`, changes `sda_pull_low` for that same byte.
- R5: If `rxne` is 1 and no read occurs when a byte's acknowledge clock ends, `btf` becomes 1 and `rx_data` keeps the older byte.
- R6: While `btf` is 1, `scl_stretch` is 1, and `bit_stb` strobes have no effect on the next byte received.
- R7: A `dr_rd` pulse while `btf` is 1 moves the waiting byte to `rx_data`, keeps `rxne` at 1, and clears `btf` and `scl_stretch` in the next cycle.
- R8: A `dr_rd` pulse while `btf` is 0 clears `rxne` in the next cycle.
- R9: With `pos_en` high, the acknowledge decision for a byte is the `ack_en` value held at the end of the previous byte's acknowledge clock, or held while idle for the first byte. Later changes to `ack_en` do not affect it.
- R10: `irq` is 1 exactly when `rxne`, `ev_irq_en` and `buf_irq_en` are all 1.
- R11: `sda_pull_low` is 0 while data bits are shifting, and `rxne` rises only in the cycle after an `ack_slot_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receive phase enabled |
| bit_stb | input | 1 | Data bit sample strobe (rising SCL) |
| sda_in | input | 1 | Sampled SDA value for `bit_stb` |
| ack_slot_stb | input | 1 | End of the acknowledge clock |
| ack_en | input | 1 | Acknowledge enable |
| pos_en | input | 1 | Acknowledge applies to the next byte |
| dr_rd | input | 1 | Holding register read strobe |
| ev_irq_en | input | 1 | Event interrupt enable |
| buf_irq_en | input | 1 | Buffer interrupt enable |
| rx_data | output | DATA_W | Holding register |
| rxne | output | 1 | Receive-full flag |
| btf | output | 1 | Byte transfer finished, bus frozen |
| scl_stretch | output | 1 | Request to hold SCL low |
| sda_pull_low | output | 1 | Request to drive SDA low (ACK) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a well-behaved clock generator. It issues no `bit_stb` during the acknowledge clock, sends exactly one `ack_slot_stb` per byte, and sends none while SCL is stretched. The stimulus issues strobes one at a time, as single-cycle pulses, in exactly that order. It never issues a read in the same cycle as an `ack_slot_stb`, so no completion race arises. Position mode is set only while idle, between byte streams.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ACK   = 2'd2,
        ST_HOLD  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/i2c_mrx_shifter.sv
module i2c_mrx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              sda_in,
    output logic [DATA_W-1:0] shift_q,
    output logic              last_bit
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last_bit = shift_en && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (shift_en) begin
            shift_q <= {shift_q[DATA_W-2:0], sda_in};
            cnt_q   <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_mrx_ackgen.sv
module i2c_mrx_ackgen (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic in_ack,
    input  logic ack_done,
    input  logic ack_en,
    input  logic pos_en,
    output logic sda_pull_low
);
    logic ack_next_q;

    // in position mode the decision for a byte is captured when the previous one ends
    always_ff @(posedge clk) begin
        if (rst)
            ack_next_q <= 1'b0;
        else if (idle || ack_done)
            ack_next_q <= ack_en;
    end

    always_comb begin
        sda_pull_low = 1'b0;
        if (in_ack)
            sda_pull_low = pos_en ? ack_next_q : ack_en;
    end
endmodule

// File: rtl/i2c_mrx_ctrl.sv
module i2c_mrx_ctrl
    import i2c_mrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_en,
    input  logic      bit_stb,
    input  logic      last_bit,
    input  logic      ack_slot_stb,
    input  logic      holding_full,
    input  logic      dr_rd,
    output rx_state_t state,
    output logic      shift_en,
    output logic      ack_done,
    output logic      in_ack,
    output logic      hold_release
);
    rx_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (rx_en) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (last_bit)                 state_d = ST_ACK;
                else if (!rx_en && !bit_stb)  state_d = ST_IDLE;
            end
            ST_ACK: begin
                if (ack_slot_stb)
                    state_d = (holding_full && !dr_rd) ? ST_HOLD : ST_SHIFT;
            end
            ST_HOLD:  if (dr_rd) state_d = ST_SHIFT;
        endcase
    end

    always_comb begin
        shift_en     = (state == ST_SHIFT) && bit_stb;
        in_ack       = (state == ST_ACK);
        ack_done     = (state == ST_ACK) && ack_slot_stb;
        hold_release = (state == ST_HOLD) && dr_rd;
    end
endmodule

// File: rtl/i2c_mrx_hold.sv
module i2c_mrx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_done,
    input  logic              hold_release,
    input  logic              frozen,
    input  logic              dr_rd,
    input  logic [DATA_W-1:0] shift_q,
    output logic [DATA_W-1:0] data_q,
    output logic              full_q
);
    logic move_now;

    assign move_now = hold_release || (ack_done && !(full_q && !dr_rd));

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (move_now) begin
                data_q <= shift_q;
                full_q <= 1'b1;
            end else if (dr_rd && !frozen) begin
                full_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_mrx_engine.sv
module i2c_mrx_engine
    import i2c_mrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              bit_stb,
    input  logic              sda_in,
    input  logic              ack_slot_stb,
    input  logic              ack_en,
    input  logic              pos_en,
    input  logic              dr_rd,
    input  logic              ev_irq_en,
    input  logic              buf_irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rxne,
    output logic              btf,
    output logic              scl_stretch,
    output logic              sda_pull_low,
    output logic              irq
);
    rx_state_t         state;
    logic              shift_en, last_bit, ack_done, in_ack, hold_release;
    logic [DATA_W-1:0] shift_q;
    logic              full_q;

    i2c_mrx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .sda_in   (sda_in),
        .shift_q  (shift_q),
        .last_bit (last_bit)
    );

    i2c_mrx_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .rx_en        (rx_en),
        .bit_stb      (bit_stb),
        .last_bit     (last_bit),
        .ack_slot_stb (ack_slot_stb),
        .holding_full (full_q),
        .dr_rd        (dr_rd),
        .state        (state),
        .shift_en     (shift_en),
        .ack_done     (ack_done),
        .in_ack       (in_ack),
        .hold_release (hold_release)
    );

    i2c_mrx_ackgen u_ack (
        .clk          (clk),
        .rst          (rst),
        .idle         (state == ST_IDLE),
        .in_ack       (in_ack),
        .ack_done     (ack_done),
        .ack_en       (ack_en),
        .pos_en       (pos_en),
        .sda_pull_low (sda_pull_low)
    );

    i2c_mrx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .ack_done     (ack_done),
        .hold_release (hold_release),
        .frozen       (state == ST_HOLD),
        .dr_rd        (dr_rd),
        .shift_q      (shift_q),
        .data_q       (rx_data),
        .full_q       (full_q)
    );

    always_comb begin
        rxne        = full_q;
        btf         = (state == ST_HOLD);
        scl_stretch = (state == ST_HOLD);
        irq         = full_q && ev_irq_en && buf_irq_en;
    end
endmodule

// File: rtl/i2c_mrx_engine_chk.sv
module i2c_mrx_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              bit_stb,
    input logic              sda_in,
    input logic              ack_slot_stb,
    input logic              ack_en,
    input logic              pos_en,
    input logic              dr_rd,
    input logic              ev_irq_en,
    input logic              buf_irq_en,
    input logic [DATA_W-1:0] rx_data,
    input logic              rxne,
    input logic              btf,
    input logic              scl_stretch,
    input logic              sda_pull_low,
    input logic              irq
);
    a_r6_stretch_in_btf: assert property (@(posedge clk) disable iff (rst)
        btf |-> scl_stretch);

    a_r5_btf_needs_rxne: assert property (@(posedge clk) disable iff (rst)
        btf |-> rxne);

    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (btf && !dr_rd) |=> (btf && $stable(rx_data)));

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (btf && dr_rd) |=> (rxne && !btf && !scl_stretch));

    a_r11_rxne_after_slot: assert property (@(posedge clk) disable iff (rst)
        $rose(rxne) |-> $past(ack_slot_stb));

    a_r3_pull_only_enabled: assert property (@(posedge clk) disable iff (rst)
        (sda_pull_low && !pos_en) |-> ack_en);

    a_r10_irq_needs_rxne: assert property (@(posedge clk) disable iff (rst)
        irq |-> rxne);
endmodule

bind i2c_mrx_engine i2c_mrx_engine_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/i2c_mrx_engine_test.sv
module i2c_mrx_engine_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0, bit_stb = 1'b0, sda_in = 1'b0, ack_slot_stb = 1'b0;
    logic       ack_en = 1'b0, pos_en = 1'b0, dr_rd = 1'b0;
    logic       ev_irq_en = 1'b0, buf_irq_en = 1'b0;
    logic [7:0] rx_data;
    logic       rxne, btf, scl_stretch, sda_pull_low, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_mrx_engine uut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .bit_stb(bit_stb), .sda_in(sda_in),
        .ack_slot_stb(ack_slot_stb), .ack_en(ack_en), .pos_en(pos_en), .dr_rd(dr_rd),
        .ev_irq_en(ev_irq_en), .buf_irq_en(buf_irq_en), .rx_data(rx_data),
        .rxne(rxne), .btf(btf), .scl_stretch(scl_stretch),
        .sda_pull_low(sda_pull_low), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // eight data bits, MSB first; checks no ACK pull while shifting
    task automatic shift_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            bit_stb = 1'b1; sda_in = b[i];
            tick();
            bit_stb = 1'b0;
            if (i == 4) check("R11 no pull while shifting", {7'd0, sda_pull_low}, 8'd0);
        end
    endtask

    task automatic end_slot();
        ack_slot_stb = 1'b1;
        tick();
        ack_slot_stb = 1'b0;
    endtask

    task automatic read_dr();
        dr_rd = 1'b1;
        tick();
        dr_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rxne", {7'd0, rxne}, 8'd0);
        check("R1 btf", {7'd0, btf}, 8'd0);
        check("R1 stretch", {7'd0, scl_stretch}, 8'd0);
        check("R1 data", rx_data, 8'h00);
    endtask

    task automatic t_basic_ack();
        ack_en = 1'b1; ev_irq_en = 1'b1; buf_irq_en = 1'b1;
        shift_byte(8'hA5);
        check("R3 ack pulled", {7'd0, sda_pull_low}, 8'd1);
        check("R11 rxne not before slot", {7'd0, rxne}, 8'd0);
        end_slot();
        check("R2 data", rx_data, 8'hA5);
        check("R2 rxne", {7'd0, rxne}, 8'd1);
        check("R10 irq on", {7'd0, irq}, 8'd1);
        buf_irq_en = 1'b0; tick();
        check("R10 irq masked", {7'd0, irq}, 8'd0);
        read_dr();
        check("R8 rxne cleared", {7'd0, rxne}, 8'd0);
    endtask

    task automatic t_nack();
        ack_en = 1'b0;
        shift_byte(8'h3C);
        check("R3 nack released", {7'd0, sda_pull_low}, 8'd0);
        end_slot();
        check("R2 data 3C", rx_data, 8'h3C);
        read_dr();
    endtask

    task automatic t_late_change();
        ack_en = 1'b0;
        shift_byte(8'h5A);
        check("R4 before change", {7'd0, sda_pull_low}, 8'd0);
        ack_en = 1'b1; tick();
        check("R4 late ack", {7'd0, sda_pull_low}, 8'd1);
        ack_en = 1'b0; tick();
        check("R4 late nack", {7'd0, sda_pull_low}, 8'd0);
        end_slot();
        read_dr();
    endtask

    task automatic t_btf();
        ack_en = 1'b1;
        shift_byte(8'h11); end_slot();
        shift_byte(8'h22); end_slot();
        check("R5 btf set", {7'd0, btf}, 8'd1);
        check("R5 old data kept", rx_data, 8'h11);
        check("R6 stretch", {7'd0, scl_stretch}, 8'd1);
        for (int i = 0; i < 3; i++) begin
            bit_stb = 1'b1; sda_in = 1'b1; tick(); bit_stb = 1'b0;
        end
        check("R6 still frozen", {7'd0, btf}, 8'd1);
        read_dr();
        check("R7 data moved", rx_data, 8'h22);
        check("R7 rxne kept", {7'd0, rxne}, 8'd1);
        check("R7 btf clear", {7'd0, btf}, 8'd0);
        check("R7 stretch clear", {7'd0, scl_stretch}, 8'd0);
        read_dr();
        check("R8 rxne clear", {7'd0, rxne}, 8'd0);
        shift_byte(8'h96); end_slot();
        check("R6 strobes ignored", rx_data, 8'h96);
        read_dr();
    endtask

    task automatic t_pos();
        rx_en = 1'b0; tick(); tick();
        pos_en = 1'b1; ack_en = 1'b1; tick();
        rx_en = 1'b1; tick();
        ack_en = 1'b0;
        shift_byte(8'hC3);
        check("R9 first byte acked", {7'd0, sda_pull_low}, 8'd1);
        end_slot();
        read_dr();
        ack_en = 1'b1;
        shift_byte(8'h3C);
        check("R9 second byte nack", {7'd0, sda_pull_low}, 8'd0);
        end_slot();
        check("R2 pos data", rx_data, 8'h3C);
        read_dr();
        pos_en = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        rx_en = 1'b1; tick();
        t_basic_ack();
        t_nack();
        t_late_change();
        t_btf();
        t_pos();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule